// File: doc/BRIEF.md
# Two-Port Network Controller Command and Status Front End

This block is the byte-wide register face of a network controller as the host sees it. A single chip select reaches two banks of command and status. The primary bank carries the time-critical work: every write there carries an opcode, a DMA channel, a pointer that picks the status byte returned on later reads, and an interrupt acknowledge. The auxiliary bank carries housekeeping: interrupt masking, power-down, reset and loading of the receive stop register. Software moves between the two banks with in-band switch commands.

Commands that the execution units must act on leave the block as a one-cycle strobe, with the opcode, the channel and the bank that issued them. The execution, receive, DMA and serial logic sit outside and are represented by stub inputs: an event pulse with its code and result bytes, the receive and execution unit states, and the bus throttle value. Reads have no side effects. The read data is a combinational selection from registered state and from those stub inputs. Host accesses and event pulses are single-cycle register transfers with no back-pressure: a write is taken on every clock edge where chip select and write enable are both high, and the block never stalls the host.

Top module: `netif_cmd_port`

## Requirements
- R1: After reset the primary bank is active, the status pointer selects byte 0, interrupts are enabled, the pending flag is clear, irq is low, no strobe is issued and the read data is 0x00.
- R2: A primary-bank write with an opcode (bits 3:0) other than 0 raises cmd_strobe for exactly the cycle after the write, with cmd_op equal to bits 3:0, cmd_chan equal to bit 4 and cmd_aux low. For opcode 15, bit 4 tells the pointer-release form (0) from the pointer-fix form (1).
- R3: A primary-bank write sets the status pointer to bits 6:5, which selects status byte 0 to 3 for every later read. Reads change neither the pointer nor the bank.
- R4: A primary-bank write with opcode 0 and bit 4 set moves to the auxiliary bank. An auxiliary-bank write with opcode 1 moves back. Neither of these, nor a primary opcode 0 with bit 4 clear, raises cmd_strobe.
- R5: An auxiliary-bank write whose bit 7 is clear sets the pointer from bits 5:4: the values 0, 1 and 2 select status bytes 4, 5 and 6, and the value 3 reads 0x00.
- R6: Auxiliary opcode 2 masks irq and opcode 3 unmasks it. Neither changes the pending flag, so irq equals pending AND enabled.
- R7: An auxiliary-bank write with bit 7 set loads bits 6:0 into the stop register. Status byte 5 reads {0, stop}. This write does not strobe and changes neither the pointer nor the bank.
- R8: An event pulse sets the pending flag and latches status byte 0 as {pending, receive event, execution event, channel, code[3:0]}, where bit 6 is set for a receive event and bit 5 for an execution event. It also latches the two result inputs into status bytes 1 and 2.
- R9: A primary-bank write with bit 7 set clears the pending flag before the command is applied. An event in the same cycle leaves the flag set.
- R10: Status byte 3 reads {rx channel, rx state[1:0], rx active, 0, exec channel, exec state[1:0]} from the stub inputs.
- R11: Opcode 14 in either bank is strobed, and it returns the front end to its reset state: primary bank, pointer 0, interrupts enabled, pending clear, power-down clear. The stop register and the latched event bytes are kept.
- R12: Auxiliary opcode 8 is strobed with cmd_aux high and sets the power-down bit 5 of status byte 4. Status byte 6 reads the throttle input unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs | input | 1 | Chip select |
| host_we | input | 1 | Write enable, qualified by chip select |
| host_wdata | input | 8 | Command byte |
| host_rdata | output | 8 | Selected status byte |
| evt_valid | input | 1 | Completion event pulse from the execution side |
| evt_rcv | input | 1 | Event came from the receive unit (else execution unit) |
| evt_chan | input | 1 | Channel of the event |
| evt_code | input | 4 | Event code |
| evt_res1 | input | 8 | First result byte |
| evt_res2 | input | 8 | Second result byte |
| rxu_chan | input | 1 | Receive unit channel |
| rxu_state | input | 2 | Receive unit state |
| rxu_active | input | 1 | Receive unit is receiving |
| exu_chan | input | 1 | Execution unit channel |
| exu_state | input | 2 | Execution unit state |
| thr_value | input | 8 | Bus throttle timer value |
| irq | output | 1 | Interrupt request |
| cmd_strobe | output | 1 | One-cycle command issue strobe |
| cmd_op | output | 4 | Issued opcode |
| cmd_chan | output | 1 | Issued DMA channel |
| cmd_aux | output | 1 | Command came from the auxiliary bank |

## Verification
The assertions check on every cycle what can be seen as a one-step relation. An event leaves the flag pending. An acknowledge alone clears it. A mask command drops irq. A strobe only ever follows a write. A stop-register write loads its low bits. The bank switches where it should. Idle and read cycles leave the pointer and the bank alone. The layout of each status byte, the pointer mapping in both banks, the value-3 hole, the race between event and acknowledge, and what a soft reset keeps and what it clears can only be shown by the bench scenarios, which read the bytes back through the host port.

// File: rtl/netif_cmd_pkg.sv
package netif_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 4;
  localparam int PTR_W  = 3;
  localparam int STOP_W = BYTE_W - 1;
  localparam int NUM_ST = 1 << PTR_W;

  // primary bank opcodes that the front end interprets itself
  localparam logic [OP_W-1:0] OP_NOP   = 4'd0;
  localparam logic [OP_W-1:0] OP_RESET = 4'd14;
  // auxiliary bank opcodes
  localparam logic [OP_W-1:0] AX_NOP   = 4'd0;
  localparam logic [OP_W-1:0] AX_TOPRI = 4'd1;
  localparam logic [OP_W-1:0] AX_IOFF  = 4'd2;
  localparam logic [OP_W-1:0] AX_ION   = 4'd3;
  localparam logic [OP_W-1:0] AX_PDOWN = 4'd8;
  localparam logic [OP_W-1:0] AX_RESET = 4'd14;

  typedef struct packed {
    logic              stop_upd;
    logic              to_aux;
    logic              to_pri;
    logic              int_off;
    logic              int_on;
    logic              soft_rst;
    logic              pwr_dn;
    logic              issue;
    logic              ack;
    logic              ptr_upd;
    logic [PTR_W-1:0]  ptr;
    logic [OP_W-1:0]   op;
    logic              chan;
  } dec_t;
endpackage

// File: rtl/netif_cmd_decode.sv
module netif_cmd_decode
  import netif_cmd_pkg::*;
(
  input  logic              aux_active,
  input  logic [BYTE_W-1:0] wdata,
  output dec_t              dec
);
  logic [OP_W-1:0] op;
  assign op = wdata[OP_W-1:0];

  always_comb begin
    dec = '0;
    dec.op = op;
    if (!aux_active) begin
      dec.chan     = wdata[4];
      dec.ack      = wdata[7];
      dec.ptr_upd  = 1'b1;
      dec.ptr      = {1'b0, wdata[6:5]};
      dec.to_aux   = (op == OP_NOP) && wdata[4];
      dec.soft_rst = (op == OP_RESET);
      dec.issue    = (op != OP_NOP);
    end else if (wdata[7]) begin
      dec.stop_upd = 1'b1;
    end else begin
      dec.ptr_upd  = 1'b1;
      dec.ptr      = {1'b1, wdata[5:4]};
      dec.to_pri   = (op == AX_TOPRI);
      dec.int_off  = (op == AX_IOFF);
      dec.int_on   = (op == AX_ION);
      dec.pwr_dn   = (op == AX_PDOWN);
      dec.soft_rst = (op == AX_RESET);
      dec.issue    = !(op == AX_NOP || op == AX_TOPRI ||
                       op == AX_IOFF || op == AX_ION);
    end
  end
endmodule

// File: rtl/netif_port_state.sv
module netif_port_state
  import netif_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  dec_t              dec,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              evt_valid,
  output logic              aux_q,
  output logic [PTR_W-1:0]  ptr_q,
  output logic              ien_q,
  output logic              pend_q,
  output logic              pdn_q,
  output logic [STOP_W-1:0] stop_q,
  output logic              stb_q,
  output logic [OP_W-1:0]   stb_op_q,
  output logic              stb_chan_q,
  output logic              stb_aux_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q  <= 1'b0;
      ptr_q  <= '0;
      ien_q  <= 1'b1;
      pdn_q  <= 1'b0;
      stop_q <= '0;
    end else if (wr) begin
      if (dec.soft_rst) begin
        aux_q <= 1'b0;
        ptr_q <= '0;
        ien_q <= 1'b1;
        pdn_q <= 1'b0;
      end else begin
        if (dec.ptr_upd)  ptr_q  <= dec.ptr;
        if (dec.to_aux)   aux_q  <= 1'b1;
        if (dec.to_pri)   aux_q  <= 1'b0;
        if (dec.int_off)  ien_q  <= 1'b0;
        if (dec.int_on)   ien_q  <= 1'b1;
        if (dec.pwr_dn)   pdn_q  <= 1'b1;
        if (dec.stop_upd) stop_q <= wdata[STOP_W-1:0];
      end
    end
  end

  // pending: clear by acknowledge or soft reset, set by event (event wins)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= 1'b0;
    else if (evt_valid)
      pend_q <= 1'b1;
    else if (wr && (dec.ack || dec.soft_rst))
      pend_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q      <= 1'b0;
      stb_op_q   <= '0;
      stb_chan_q <= 1'b0;
      stb_aux_q  <= 1'b0;
    end else begin
      stb_q <= wr && dec.issue;
      if (wr && dec.issue) begin
        stb_op_q   <= dec.op;
        stb_chan_q <= dec.chan;
        stb_aux_q  <= aux_q;
      end
    end
  end
endmodule

// File: rtl/netif_status_bank.sv
module netif_status_bank
  import netif_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic              evt_rcv,
  input  logic              evt_chan,
  input  logic [OP_W-1:0]   evt_code,
  input  logic [BYTE_W-1:0] evt_res1,
  input  logic [BYTE_W-1:0] evt_res2,
  input  logic              pend,
  input  logic              pdn,
  input  logic [STOP_W-1:0] stop,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              rxu_chan,
  input  logic [1:0]        rxu_state,
  input  logic              rxu_active,
  input  logic              exu_chan,
  input  logic [1:0]        exu_state,
  input  logic [BYTE_W-1:0] thr_value,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-2:0] ev_q;
  logic [BYTE_W-1:0] r1_q, r2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q <= '0;
      r1_q <= '0;
      r2_q <= '0;
    end else if (evt_valid) begin
      ev_q <= {evt_rcv, !evt_rcv, evt_chan, evt_code};
      r1_q <= evt_res1;
      r2_q <= evt_res2;
    end
  end

  logic [BYTE_W-1:0] bytes [NUM_ST];

  for (genvar i = 0; i < NUM_ST; i++) begin : g_sel
    if (i == 0)      begin : g_s0 assign bytes[i] = {pend, ev_q}; end
    else if (i == 1) begin : g_s1 assign bytes[i] = r1_q; end
    else if (i == 2) begin : g_s2 assign bytes[i] = r2_q; end
    else if (i == 3) begin : g_s3
      assign bytes[i] = {rxu_chan, rxu_state, rxu_active, 1'b0, exu_chan, exu_state};
    end
    else if (i == 4) begin : g_s4 assign bytes[i] = {2'b00, pdn, 5'b00000}; end
    else if (i == 5) begin : g_s5 assign bytes[i] = {1'b0, stop}; end
    else if (i == 6) begin : g_s6 assign bytes[i] = thr_value; end
    else             begin : g_sx assign bytes[i] = '0; end
  end

  assign rdata = bytes[ptr];
endmodule

// File: rtl/netif_cmd_port.sv
module netif_cmd_port
  import netif_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs,
  input  logic              host_we,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              evt_valid,
  input  logic              evt_rcv,
  input  logic              evt_chan,
  input  logic [3:0]        evt_code,
  input  logic [7:0]        evt_res1,
  input  logic [7:0]        evt_res2,
  input  logic              rxu_chan,
  input  logic [1:0]        rxu_state,
  input  logic              rxu_active,
  input  logic              exu_chan,
  input  logic [1:0]        exu_state,
  input  logic [7:0]        thr_value,
  output logic              irq,
  output logic              cmd_strobe,
  output logic [3:0]        cmd_op,
  output logic              cmd_chan,
  output logic              cmd_aux
);
  logic              wr;
  dec_t              dec;
  logic              aux_q, ien_q, pend_q, pdn_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [STOP_W-1:0] stop_q;

  assign wr = host_cs && host_we;

  netif_cmd_decode u_dec (
    .aux_active (aux_q),
    .wdata      (host_wdata),
    .dec        (dec)
  );

  netif_port_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (wr),
    .dec        (dec),
    .wdata      (host_wdata),
    .evt_valid  (evt_valid),
    .aux_q      (aux_q),
    .ptr_q      (ptr_q),
    .ien_q      (ien_q),
    .pend_q     (pend_q),
    .pdn_q      (pdn_q),
    .stop_q     (stop_q),
    .stb_q      (cmd_strobe),
    .stb_op_q   (cmd_op),
    .stb_chan_q (cmd_chan),
    .stb_aux_q  (cmd_aux)
  );

  netif_status_bank u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .evt_rcv    (evt_rcv),
    .evt_chan   (evt_chan),
    .evt_code   (evt_code),
    .evt_res1   (evt_res1),
    .evt_res2   (evt_res2),
    .pend       (pend_q),
    .pdn        (pdn_q),
    .stop       (stop_q),
    .ptr        (ptr_q),
    .rxu_chan   (rxu_chan),
    .rxu_state  (rxu_state),
    .rxu_active (rxu_active),
    .exu_chan   (exu_chan),
    .exu_state  (exu_state),
    .thr_value  (thr_value),
    .rdata      (host_rdata)
  );

  assign irq = pend_q && ien_q;
endmodule

// File: rtl/netif_cmd_port_chk.sv
module netif_cmd_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_cs,
  input logic       host_we,
  input logic [7:0] host_wdata,
  input logic       evt_valid,
  input logic       irq,
  input logic       cmd_strobe,
  input logic       aux_q,
  input logic       pend_q,
  input logic [2:0] ptr_q,
  input logic [6:0] stop_q
);
  logic wr_c;
  assign wr_c = host_cs && host_we;

  p_event_pends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> pend_q);

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && !aux_q && host_wdata[7] && !evt_valid) |=> !pend_q);

  p_mask_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && aux_q && !host_wdata[7] && host_wdata[3:0] == 4'd2) |=> !irq);

  p_strobe_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> $past(wr_c));

  p_stop_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && aux_q && host_wdata[7]) |=> (stop_q == $past(host_wdata[6:0])));

  p_switch_aux_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && !aux_q && host_wdata[4:0] == 5'b10000) |=> aux_q);

  p_read_pure_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_c |=> ($stable(ptr_q) && $stable(aux_q)));
endmodule

bind netif_cmd_port netif_cmd_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_cs    (host_cs),
  .host_we    (host_we),
  .host_wdata (host_wdata),
  .evt_valid  (evt_valid),
  .irq        (irq),
  .cmd_strobe (cmd_strobe),
  .aux_q      (aux_q),
  .pend_q     (pend_q),
  .ptr_q      (ptr_q),
  .stop_q     (stop_q)
);

// File: tb/netif_cmd_port_bench.sv
module netif_cmd_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_cs = 1'b0, host_we = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       evt_valid = 1'b0, evt_rcv = 1'b0, evt_chan = 1'b0;
  logic [3:0] evt_code = '0;
  logic [7:0] evt_res1 = '0, evt_res2 = '0;
  logic       rxu_chan = 1'b0, rxu_active = 1'b0, exu_chan = 1'b0;
  logic [1:0] rxu_state = '0, exu_state = '0;
  logic [7:0] thr_value = '0;
  logic       irq, cmd_strobe, cmd_chan, cmd_aux;
  logic [3:0] cmd_op;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  netif_cmd_port u_netif_cmd_port (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .evt_valid(evt_valid), .evt_rcv(evt_rcv), .evt_chan(evt_chan),
    .evt_code(evt_code), .evt_res1(evt_res1), .evt_res2(evt_res2),
    .rxu_chan(rxu_chan), .rxu_state(rxu_state), .rxu_active(rxu_active),
    .exu_chan(exu_chan), .exu_state(exu_state), .thr_value(thr_value),
    .irq(irq), .cmd_strobe(cmd_strobe), .cmd_op(cmd_op),
    .cmd_chan(cmd_chan), .cmd_aux(cmd_aux)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge (after capture)
  task automatic wr_byte(logic [7:0] d, logic ev = 1'b0);
    @(negedge clk);
    host_cs = 1'b1; host_we = 1'b1; host_wdata = d; evt_valid = ev;
    @(negedge clk);
    host_cs = 1'b0; host_we = 1'b0; evt_valid = 1'b0;
  endtask

  task automatic fire_evt(logic rcv, logic ch, logic [3:0] code,
                          logic [7:0] r1, logic [7:0] r2);
    @(negedge clk);
    evt_valid = 1'b1; evt_rcv = rcv; evt_chan = ch; evt_code = code;
    evt_res1 = r1; evt_res2 = r2;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rdata", host_rdata, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 strobe", {7'd0, cmd_strobe}, 8'h00);
  endtask

  task automatic t_primary_decode();
    wr_byte(8'h14);
    check("R2 strobe", {7'd0, cmd_strobe}, 8'h01);
    check("R2 op", {4'd0, cmd_op}, 8'h04);
    check("R2 chan", {7'd0, cmd_chan}, 8'h01);
    check("R2 aux", {7'd0, cmd_aux}, 8'h00);
    @(negedge clk);
    check("R2 one cycle", {7'd0, cmd_strobe}, 8'h00);
    wr_byte(8'h0F);
    check("R2 rls op", {4'd0, cmd_op}, 8'h0F);
    check("R2 rls chan", {7'd0, cmd_chan}, 8'h00);
    wr_byte(8'h1F);
    check("R2 fix chan", {7'd0, cmd_chan}, 8'h01);
    wr_byte(8'h00);
    check("R4 nop no strobe", {7'd0, cmd_strobe}, 8'h00);
  endtask

  task automatic t_status_read();
    fire_evt(1'b0, 1'b1, 4'd4, 8'hA5, 8'h3C);
    check("R8 s0 exec", host_rdata, 8'hB4);
    check("R6 irq on", {7'd0, irq}, 8'h01);
    wr_byte(8'h20);
    check("R8 s1", host_rdata, 8'hA5);
    repeat (3) @(negedge clk);
    check("R3 pure read", host_rdata, 8'hA5);
    wr_byte(8'h40);
    check("R8 s2", host_rdata, 8'h3C);
    rxu_chan = 1'b1; rxu_state = 2'd2; rxu_active = 1'b1;
    exu_chan = 1'b0; exu_state = 2'd3;
    wr_byte(8'h60);
    #1 check("R10 s3", host_rdata, 8'hD3);
    wr_byte(8'h80);
    check("R9 ack clears", host_rdata, 8'h34);
    check("R9 irq low", {7'd0, irq}, 8'h00);
    fire_evt(1'b1, 1'b0, 4'd8, 8'h11, 8'h22);
    check("R8 s0 rcv", host_rdata, 8'hC8);
    wr_byte(8'h80, 1'b1);
    check("R9 event wins", host_rdata, 8'hC8);
    check("R9 irq kept", {7'd0, irq}, 8'h01);
    wr_byte(8'h80);
  endtask

  task automatic t_aux_bank();
    wr_byte(8'h10);
    check("R4 to aux no strobe", {7'd0, cmd_strobe}, 8'h00);
    wr_byte(8'h10);
    check("R5 s5 init", host_rdata, 8'h00);
    wr_byte(8'hD5);
    check("R7 stop value", host_rdata, 8'h55);
    check("R7 no strobe", {7'd0, cmd_strobe}, 8'h00);
    wr_byte(8'h08);
    check("R12 pd strobe", {7'd0, cmd_strobe}, 8'h01);
    check("R12 pd op", {4'd0, cmd_op}, 8'h08);
    check("R12 pd aux", {7'd0, cmd_aux}, 8'h01);
    check("R12 s4", host_rdata, 8'h20);
    thr_value = 8'h9A;
    wr_byte(8'h20);
    check("R12 s6", host_rdata, 8'h9A);
    wr_byte(8'h30);
    check("R5 hole", host_rdata, 8'h00);
    fire_evt(1'b0, 1'b0, 4'd2, 8'h00, 8'h00);
    check("R6 irq pend", {7'd0, irq}, 8'h01);
    wr_byte(8'h02);
    check("R6 masked", {7'd0, irq}, 8'h00);
    check("R6 no strobe", {7'd0, cmd_strobe}, 8'h00);
    wr_byte(8'h03);
    check("R6 unmasked", {7'd0, irq}, 8'h01);
    wr_byte(8'h01);
    check("R4 to pri no strobe", {7'd0, cmd_strobe}, 8'h00);
    wr_byte(8'h85);
    check("R4 pri op", {4'd0, cmd_op}, 8'h05);
    check("R4 pri aux", {7'd0, cmd_aux}, 8'h00);
    check("R9 ack", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_soft_reset();
    wr_byte(8'h10);
    wr_byte(8'h02);
    fire_evt(1'b0, 1'b1, 4'd13, 8'h00, 8'h00);
    check("R6 masked pend", {7'd0, irq}, 8'h00);
    wr_byte(8'h0E);
    check("R11 strobe", {7'd0, cmd_strobe}, 8'h01);
    check("R11 op", {4'd0, cmd_op}, 8'h0E);
    check("R11 aux", {7'd0, cmd_aux}, 8'h01);
    check("R11 s0 kept", host_rdata, 8'h3D);
    wr_byte(8'h04);
    check("R11 primary", {7'd0, cmd_aux}, 8'h00);
    fire_evt(1'b0, 1'b0, 4'd4, 8'h00, 8'h00);
    check("R11 enabled", {7'd0, irq}, 8'h01);
    wr_byte(8'h90);
    wr_byte(8'h10);
    check("R11 stop kept", host_rdata, 8'h55);
    wr_byte(8'h00);
    check("R11 pd clear", host_rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_primary_decode();
    t_status_read();
    t_aux_bank();
    t_soft_reset();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule